// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block sits on the host side of a 3-wire serial analog-to-digital converter and fetches one 12-bit conversion each time it is triggered. It runs from a fast system clock and generates an active-low chip select, a matching active-low output enable, a serial clock that idles high, and a select line that tells the converter which input coding or channel to use. It reads the converter's single data line, takes 16 bits per frame, and returns a 16-bit parallel word with a one-cycle valid strobe, a flag for signed coding and a flag for a bad frame.

Every minimum timing comes from the system clock frequency parameter and is expressed as a count of system clocks. This covers chip-select setup, the chip-select gap between frames and the serial clock half period. A divider input sets the serial clock half period, and the block clamps that value into the legal range. The frame always has 16 clocks: 4 bits that must be zero, then 12 data bits sent most significant bit first. The 12 data bits are zero-extended for straight binary coding or sign-extended for two's complement coding.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, cs_n, oe_n and sclk are high and result_valid is low.
- R2: A start pulse starts a frame only when no frame is running and chip select has been high for at least CSW_CYC system clocks (4 at 50 MHz). Any other start pulse is ignored: cs_n stays high, and a running frame goes on unchanged.
- R3: The first sclk fall comes exactly CSS_CYC system clocks after cs_n falls (4 at 50 MHz). Between two frames, cs_n stays high for at least CSW_CYC system clocks.
- R4: sclk is high whenever cs_n is high. Each low phase and each high phase lasts H system clocks. H is div_half clamped to the range 5 to 250 at 50 MHz, which gives a 100 ns to 5 us half period, and H is captured when the frame starts.
- R5: Each frame has exactly 16 sclk low/high cycles. cs_n rises at the end of the 16th high phase.
- R6: sdi is sampled once per rising sclk edge. The first sample is frame bit 15, most significant first. Bits 15:12 are the leading bits and bits 11:0 are the data.
- R7: sel_line is captured at start and held constant while cs_n is low. With SEL_IS_CHAN=0, sel_line is the inverse of req_sel, so high means straight binary.
- R8: With SEL_IS_CHAN=0 and req_sel=1, result is the 12 data bits sign-extended from bit 11 and result_signed is 1. With req_sel=0, result is zero-extended and result_signed is 0.
- R9: frame_err is 1 together with result_valid exactly when any of frame bits 15:12 is 1.
- R10: result_valid is a one-cycle pulse. It goes high CSS_CYC + 32*H + 1 system clocks after the clock edge that accepted start.
- R11: oe_n equals cs_n at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one frame read |
| div_half | input | DIV_W | Requested sclk half period in system clocks |
| req_sel | input | 1 | Coding request (1 = two's complement), or channel number if SEL_IS_CHAN=1 |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| oe_n | output | 1 | Active-low output enable, tied to chip select |
| sclk | output | 1 | Serial clock, idles high |
| sel_line | output | 1 | Coding or channel select to the converter |
| result | output | 16 | Extended conversion result |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| result_signed | output | 1 | Result uses two's complement coding |
| frame_err | output | 1 | A leading bit of the frame was non-zero |

## Verification
The result is due CSS_CYC + 32*H + 1 cycles after the edge that accepts start. The bench counts falling system-clock samples from the start pulse and compares that count with the value computed from the clamped divider. Chip-select setup, the sclk phase lengths, the number of sclk cycles and the chip-select gap are measured in the same way, by counting samples between edges of the outputs. The converter model changes sdi half a system cycle after each sclk fall, so every sampled bit is stable well before the rising edge that uses it. Ignored start pulses are checked by watching cs_n for several cycles after the pulse.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int FRAME_BITS = 16;
    localparam int DATA_BITS  = 12;
    localparam int LEAD_BITS  = FRAME_BITS - DATA_BITS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } rd_state_e;

    // System clocks covering at least ns nanoseconds.
    function automatic int cycles_ceil(input int hz, input int ns);
        return ((hz / 1000) * ns + 999_999) / 1_000_000;
    endfunction

    // System clocks not exceeding ns nanoseconds.
    function automatic int cycles_floor(input int hz, input int ns);
        return ((hz / 1000) * ns) / 1_000_000;
    endfunction

endpackage

// File: rtl/adcrd_seq.sv
module adcrd_seq #(
    parameter int DIV_W    = 8,
    parameter int CSS_CYC  = 4,
    parameter int CSW_CYC  = 4,
    parameter int MIN_HALF = 5,
    parameter int MAX_HALF = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_half,
    input  logic             sel_req,
    output logic             cs_n,
    output logic             sclk,
    output logic             sample,
    output logic             done,
    output logic             sel_held
);
    import adcrd_pkg::*;

    localparam int CNT_TOP = (MAX_HALF > CSS_CYC) ? MAX_HALF : CSS_CYC;
    localparam int CNT_W   = $clog2(CNT_TOP + 1);
    localparam int GAP_W   = $clog2(CSW_CYC + 1);
    localparam int BIT_W   = $clog2(FRAME_BITS);

    typedef struct packed {
        rd_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] half;
        logic [BIT_W-1:0] bitn;
        logic [GAP_W-1:0] gap;
        logic             cs_n;
        logic             sclk;
        logic             sample;
        logic             done;
        logic             sel;
    } seq_regs_t;

    seq_regs_t        r_q, r_d;
    logic [CNT_W-1:0] half_lim;

    always_comb begin
        if (int'(div_half) < MIN_HALF)      half_lim = CNT_W'(MIN_HALF);
        else if (int'(div_half) > MAX_HALF) half_lim = CNT_W'(MAX_HALF);
        else                                half_lim = CNT_W'(div_half);
    end

    always_comb begin
        r_d        = r_q;
        r_d.sample = 1'b0;
        r_d.done   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (r_q.gap != GAP_W'(CSW_CYC)) r_d.gap = r_q.gap + 1'b1;
                if (start && (r_q.gap == GAP_W'(CSW_CYC))) begin
                    r_d.st   = ST_SETUP;
                    r_d.cs_n = 1'b0;
                    r_d.cnt  = '0;
                    r_d.half = half_lim;
                    r_d.sel  = sel_req;
                    r_d.bitn = '0;
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == CNT_W'(CSS_CYC - 1)) begin
                    r_d.st   = ST_LOW;
                    r_d.sclk = 1'b0;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_LOW: begin
                if (r_q.cnt == r_q.half - CNT_W'(1)) begin
                    r_d.st     = ST_HIGH;
                    r_d.sclk   = 1'b1;
                    r_d.sample = 1'b1;
                    r_d.cnt    = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                if (r_q.cnt == r_q.half - CNT_W'(1)) begin
                    r_d.cnt = '0;
                    if (r_q.bitn == BIT_W'(FRAME_BITS - 1)) begin
                        r_d.st   = ST_IDLE;
                        r_d.cs_n = 1'b1;
                        r_d.done = 1'b1;
                        r_d.gap  = '0;
                        r_d.bitn = '0;
                    end else begin
                        r_d.st   = ST_LOW;
                        r_d.sclk = 1'b0;
                        r_d.bitn = r_q.bitn + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.half   <= CNT_W'(MIN_HALF);
            r_q.gap    <= GAP_W'(CSW_CYC);
            r_q.cs_n   <= 1'b1;
            r_q.sclk   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n     = r_q.cs_n;
    assign sclk     = r_q.sclk;
    assign sample   = r_q.sample;
    assign done     = r_q.done;
    assign sel_held = r_q.sel;

    p_idle_clk_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(r_q.gap) == GAP_W'(CSW_CYC)));
    p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> (sclk && !cs_n));
    p_low_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |=> !sclk);
    p_frame_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(r_q.bitn) == BIT_W'(FRAME_BITS - 1)));
    p_sample_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (sclk && !$past(sclk)));

endmodule

// File: rtl/adcrd_shift.sv
module adcrd_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             sdi,
    output logic [WIDTH-1:0] word
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } sh_regs_t;

    sh_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (sample) r_d.sr = {r_q.sr[WIDTH-2:0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign word = r_q.sr;

endmodule

// File: rtl/adcrd_fmt.sv
module adcrd_fmt (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        done,
    input  logic        use_signed,
    input  logic [15:0] word,
    output logic [15:0] result,
    output logic        valid,
    output logic        is_signed,
    output logic        err
);
    import adcrd_pkg::*;

    typedef struct packed {
        logic [FRAME_BITS-1:0] res;
        logic                  vld;
        logic                  sgn;
        logic                  err;
    } fmt_regs_t;

    fmt_regs_t            r_q, r_d;
    logic [DATA_BITS-1:0] data;

    assign data = word[DATA_BITS-1:0];

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (done) begin
            r_d.vld = 1'b1;
            r_d.sgn = use_signed;
            r_d.err = |word[FRAME_BITS-1:DATA_BITS];
            if (use_signed) r_d.res = {{LEAD_BITS{data[DATA_BITS-1]}}, data};
            else            r_d.res = {{LEAD_BITS{1'b0}}, data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result    = r_q.res;
    assign valid     = r_q.vld;
    assign is_signed = r_q.sgn;
    assign err       = r_q.err;

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    p_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && is_signed) |-> (result[15:12] == {4{result[11]}}));
    p_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !is_signed) |-> (result[15:12] == 4'h0));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int DIV_W       = 8,
    parameter int SEL_IS_CHAN = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_half,
    input  logic             req_sel,
    input  logic             sdi,
    output logic             cs_n,
    output logic             oe_n,
    output logic             sclk,
    output logic             sel_line,
    output logic [15:0]      result,
    output logic             result_valid,
    output logic             result_signed,
    output logic             frame_err
);
    import adcrd_pkg::*;

    localparam int CSS_CYC  = cycles_ceil(CLK_HZ, 80);
    localparam int CSW_CYC  = cycles_ceil(CLK_HZ, 80);
    localparam int MIN_HALF = cycles_ceil(CLK_HZ, 100);
    localparam int MAX_HALF = cycles_floor(CLK_HZ, 5000);

    logic                  sample, done, sel_held, fmt_signed;
    logic [FRAME_BITS-1:0] word;

    adcrd_seq #(
        .DIV_W    (DIV_W),
        .CSS_CYC  (CSS_CYC),
        .CSW_CYC  (CSW_CYC),
        .MIN_HALF (MIN_HALF),
        .MAX_HALF (MAX_HALF)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .div_half (div_half),
        .sel_req  (req_sel),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sample   (sample),
        .done     (done),
        .sel_held (sel_held)
    );

    adcrd_shift #(.WIDTH(FRAME_BITS)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .sdi    (sdi),
        .word   (word)
    );

    generate
        if (SEL_IS_CHAN != 0) begin : g_chan
            assign sel_line   = sel_held;
            assign fmt_signed = 1'b0;
        end else begin : g_coding
            assign sel_line   = ~sel_held;
            assign fmt_signed = sel_held;
        end
    endgenerate

    adcrd_fmt i_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .use_signed (fmt_signed),
        .word       (word),
        .result     (result),
        .valid      (result_valid),
        .is_signed  (result_signed),
        .err        (frame_err)
    );

    assign oe_n = cs_n;

    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(sel_line));

endmodule

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;

    localparam int CSS = 4;
    localparam int CSW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  div_half = 8'd5;
    logic        req_sel = 1'b0;
    logic        sdi = 1'b0;
    logic        cs_n, oe_n, sclk, sel_line;
    logic [15:0] result;
    logic        result_valid, result_signed, frame_err;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_frame_reader i_adc_frame_reader (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .div_half      (div_half),
        .req_sel       (req_sel),
        .sdi           (sdi),
        .cs_n          (cs_n),
        .oe_n          (oe_n),
        .sclk          (sclk),
        .sel_line      (sel_line),
        .result        (result),
        .result_valid  (result_valid),
        .result_signed (result_signed),
        .frame_err     (frame_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_half(input int d);
        if (d < 5)   return 5;
        if (d > 250) return 250;
        return d;
    endfunction

    function automatic logic [15:0] exp_word(input logic bip, input logic [11:0] d);
        return bip ? {{4{d[11]}}, d} : {4'h0, d};
    endfunction

    // converter model plus interface monitor, sampled on falling system clock
    logic [15:0] fw = 16'h0;
    int  bidx = 0;
    int  cur_half = 5;
    bit  mon_on = 1'b0;
    bit  prev_cs = 1'b1, prev_sclk = 1'b1, first_seen = 1'b0, had_frame = 1'b0;
    bit  oe_bad = 1'b0, sel_bad = 1'b0, sel_at_fall = 1'b0;
    int  setup_cnt = 0, low_run = 0, high_run = 0, falls = 0, gap_run = 0;

    always @(negedge clk) begin
        if (cs_n) bidx = 0;
        else if (prev_sclk && !sclk && bidx < 16) begin
            sdi <= fw[15 - bidx];
            bidx = bidx + 1;
        end
        if (mon_on) begin
            if (oe_n !== cs_n) oe_bad = 1'b1;
            if (prev_cs && !cs_n) begin
                if (had_frame) check(gap_run >= CSW, "R3 cs gap", gap_run, CSW);
                setup_cnt = 1; falls = 0; low_run = 0; high_run = 0;
                first_seen = 1'b0; sel_at_fall = sel_line; sel_bad = 1'b0;
            end else if (!cs_n) begin
                if (sel_line !== sel_at_fall) sel_bad = 1'b1;
                if (prev_sclk && !sclk) begin
                    if (!first_seen) check(setup_cnt == CSS, "R3 setup", setup_cnt, CSS);
                    else check(high_run == cur_half, "R4 high phase", high_run, cur_half);
                    first_seen = 1'b1;
                    falls++;
                    low_run = 1;
                end else if (!sclk) begin
                    low_run++;
                end else if (!prev_sclk && sclk) begin
                    check(low_run == cur_half, "R4 low phase", low_run, cur_half);
                    high_run = 1;
                end else begin
                    if (!first_seen) setup_cnt++;
                    else high_run++;
                end
            end else if (!prev_cs && cs_n) begin
                check(falls == 16, "R5 sclk count", falls, 16);
                check(high_run == cur_half, "R5 last high phase", high_run, cur_half);
                check(!oe_bad, "R11 oe_n follows cs_n", oe_bad, 0);
                check(!sel_bad, "R7 sel stable", sel_bad, 0);
                check(sclk === 1'b1, "R4 idle high", sclk, 1);
                had_frame = 1'b1;
                gap_run = 1;
            end else begin
                gap_run++;
                if (sclk !== 1'b1) oe_bad = 1'b1;
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic do_frame(input int div, input bit sel, input logic [11:0] d,
                            input logic [3:0] lead, input bit mid_start);
        int n, lat;
        logic [15:0] ew;
        fw = {lead, d};
        cur_half = exp_half(div);
        div_half = 8'(div);
        req_sel = sel;
        lat = CSS + 32 * cur_half + 2;
        n = 0;
        start = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) start = 1'b0;
            if (n == 2) check(sel_line == !sel, "R7 sel polarity", sel_line, !sel);
            if (mid_start) start = (n == 50);
        end while (!result_valid && n < 20000);
        start = 1'b0;
        ew = exp_word(sel, d);
        check(n == lat, "R10 latency", n, lat);
        check(result == ew, "R6 R8 result", result, ew);
        check(result_signed == sel, "R8 signed flag", result_signed, sel);
        check(frame_err == (lead != 4'h0), "R9 frame_err", frame_err, lead != 4'h0);
        // start while gap not yet elapsed must be ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!result_valid, "R10 single pulse", result_valid, 0);
        repeat (3) begin
            @(negedge clk);
            check(cs_n === 1'b1, "R2 early start ignored", cs_n, 1);
        end
        repeat (CSW) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1 && oe_n === 1'b1, "R1 cs/oe reset", {cs_n, oe_n}, 3);
        check(sclk === 1'b1, "R1 sclk reset", sclk, 1);
        check(result_valid === 1'b0, "R1 valid reset", result_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        prev_cs = cs_n;
        prev_sclk = sclk;

        // directed corners
        do_frame(5,   1'b0, 12'h800, 4'h0, 1'b0);  // R6 MSB only, unipolar
        do_frame(5,   1'b0, 12'h001, 4'h0, 1'b0);  // R6 LSB only
        do_frame(5,   1'b1, 12'h800, 4'h0, 1'b0);  // R8 most negative
        do_frame(5,   1'b1, 12'h7FF, 4'h0, 1'b0);  // R8 most positive
        do_frame(0,   1'b0, 12'hFFF, 4'h0, 1'b0);  // R4 clamp low
        do_frame(255, 1'b1, 12'hA5C, 4'h0, 1'b0);  // R4 clamp high
        do_frame(7,   1'b0, 12'h3C3, 4'h8, 1'b0);  // R9 leading bit 15 set
        do_frame(6,   1'b1, 12'h0F0, 4'h1, 1'b1);  // R9 bit 12, R2 start mid-frame
        // random frames
        for (int i = 0; i < 40; i++) begin
            int dv;
            logic [3:0] ld;
            dv = $urandom_range(0, 12);
            ld = ($urandom_range(0, 4) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
            do_frame(dv, 1'($urandom_range(0, 1)), 12'($urandom), ld,
                     $urandom_range(0, 3) == 0);
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule